// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer

A single timer channel with a counter of configurable width. A control word picks one of several behaviours:
- a one-shot timer that counts a programmed span once and then halts;
- a periodic timer that reloads and runs forever;
- a pulse-width modulator with a programmable period and duty;
- a capture unit that watches an external pin.

The capture unit works in one of two ways. It can count pin edges down to a threshold, or it can timestamp each pin edge against a free-running counter.

Software drives a four-address write port. Through it software programs the control word, the reload value and the compare value, and clears sticky event flags. The pin passes through a synchronizer before its rising edges are detected. The block exposes the live counter, the latest capture result, the modulated output, the enable state and three sticky flags: timeout, compare and capture.

Top module: `gpt_timer`

## Requirements
- R1: After reset, the control word, reload value, compare value, counter, capture register and all three flags are zero, and `run_o` and `pwm_o` are low.
- R2: Address 0 holds the control word. Its bits are: [1:0] mode (0 reserved, 1 one-shot, 2 periodic, 3 capture), [2] capture kind (0 edge-count, 1 edge-time), [3] alternate select (0 capture, 1 PWM), [4] up-count, [5] compare-flag enable, [6] enable. Any combination that maps to no operation leaves the counter holding its initial value. This covers mode 0, and it covers alternate select with capture kind set.
- R3: Address 1 holds the reload value and address 2 the compare value. A write to address 0 reinitialises the counter on the next clock edge: to zero for an up-counting timer, otherwise to the reload value. Counting proceeds from the edge after that.
- R4: In one-shot mode counting down, the counter steps down from the reload value by one per cycle. On the edge where it is zero, it sets the timeout flag and clears the enable bit, and the counter stays at zero.
- R5: In periodic mode, reaching the end value sets the timeout flag and reloads, giving a period of reload+1 cycles.
- R6: In one-shot and periodic modes with up-count set, the counter starts at zero and rises by one per cycle. The end value is the reload value.
- R7: PWM runs only when alternate select is 1, capture kind is 0 and mode is 1 or 2. It always counts down, whatever the up-count bit says. The output goes high at start and on every reload from zero. It goes low on the edge where the counter equals the compare value, so each period of reload+1 cycles holds compare low cycles. In every other mode `pwm_o` is low.
- R8: The compare flag (flag bit 1) is set on the edge where the counter equals the compare value. This happens only when the compare-flag enable bit is set, and only in one-shot or periodic mode.
- R9: In edge-count mode, each detected pin edge decrements the counter and copies the new count to `capt_o`. When the new count equals the compare value, the capture flag (bit 2) is set and the counter reloads.
- R10: In edge-time mode, the counter runs down freely and reloads after zero. Each detected pin edge copies the current count into `capt_o` and sets the capture flag.
- R11: The pin is sampled by two flops, and only a low-to-high transition counts. An edge driven before clock edge k acts on edge k+2. A pin held high counts once.
- R12: Flags are sticky. A write to address 3 clears each flag whose data bit is 1 (bit 0 timeout, bit 1 compare, bit 2 capture) and leaves the others. A flag set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 reload, 2 compare, 3 flag clear) |
| wr_data | input | CNT_W | Write data |
| cap_in | input | 1 | Asynchronous capture pin |
| pwm_o | output | 1 | Modulated output |
| capt_o | output | CNT_W | Latest capture result |
| cnt_o | output | CNT_W | Live counter value |
| run_o | output | 1 | Enable bit of the control word |
| irq_to_o | output | 1 | Sticky timeout flag |
| irq_mt_o | output | 1 | Sticky compare flag |
| irq_cap_o | output | 1 | Sticky capture flag |

## Verification
The checker keeps its own copy of the control word, taken from the write port, and it assumes that no write other than through that port changes the mode bits. The up-start and PWM step properties assume that no second control write lands within two cycles of the first. The stimulus therefore spaces every register write one full cycle apart and never writes the control word twice in a row. The pin is driven only at falling clock edges and is held for several cycles, so each pulse is seen exactly once by the synchronizer.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_LOAD  = 2'd1;
   localparam logic [1:0] A_MATCH = 2'd2;
   localparam logic [1:0] A_CLEAR = 2'd3;

   localparam int FLG_TO  = 0;
   localparam int FLG_MT  = 1;
   localparam int FLG_CAP = 2;
   localparam int N_FLG   = 3;

   typedef struct packed {
      logic       en;
      logic       ie;
      logic       up;
      logic       alt;
      logic       kind;
      logic [1:0] mode;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_ONESHOT,
      OP_PERIODIC,
      OP_EDGE_CNT,
      OP_EDGE_TIME,
      OP_PWM
   } op_e;

   function automatic op_e decode_op(input ctrl_t c);
      op_e r;
      r = OP_IDLE;
      if (c.alt) begin
         if (!c.kind && (c.mode == 2'd1 || c.mode == 2'd2)) r = OP_PWM;
      end else begin
         case (c.mode)
            2'd1:    r = OP_ONESHOT;
            2'd2:    r = OP_PERIODIC;
            2'd3:    r = c.kind ? OP_EDGE_TIME : OP_EDGE_CNT;
            default: r = OP_IDLE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              stop_req,
   input  logic [N_FLG-1:0]  flag_set,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  load_v,
   output logic [CNT_W-1:0]  match_v,
   output logic              restart,
   output logic [N_FLG-1:0]  flags
);

   logic ctrl_wr, load_wr, match_wr, clr_wr;
   logic [N_FLG-1:0] clr_mask;
   logic unused_hi;

   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
   assign load_wr  = wr_en && (wr_addr == A_LOAD);
   assign match_wr = wr_en && (wr_addr == A_MATCH);
   assign clr_wr   = wr_en && (wr_addr == A_CLEAR);
   assign clr_mask = clr_wr ? wr_data[N_FLG-1:0] : '0;
   assign unused_hi = ^wr_data[CNT_W-1:CTRL_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         load_v  <= '0;
         match_v <= '0;
         restart <= 1'b0;
         flags   <= '0;
      end else begin
         restart <= ctrl_wr;
         if (ctrl_wr)
            ctrl <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
         else if (stop_req)
            ctrl.en <= 1'b0;
         if (load_wr)  load_v  <= wr_data;
         if (match_wr) match_v <= wr_data;
         flags <= (flags & ~clr_mask) | flag_set;
      end
   end

endmodule

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/gpt_core.sv
module gpt_core
   import gpt_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic              en,
   input  logic              up,
   input  logic              ie,
   input  logic [CNT_W-1:0]  load_v,
   input  logic [CNT_W-1:0]  match_v,
   input  logic              restart,
   input  logic              rise,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  capt,
   output logic              pwm_q,
   output logic [N_FLG-1:0]  flag_set,
   output logic              stop_req
);

   logic [CNT_W-1:0] cnt_n, capt_n, dec, inc;
   logic             pwm_n, timer_op, count_up, at_end;

   assign dec      = cnt - 1'b1;
   assign inc      = cnt + 1'b1;
   assign timer_op = (op == OP_ONESHOT) || (op == OP_PERIODIC);
   assign count_up = timer_op && up;
   assign at_end   = count_up ? (cnt == load_v) : (cnt == '0);

   always_comb begin
      cnt_n    = cnt;
      capt_n   = capt;
      pwm_n    = pwm_q;
      flag_set = '0;
      stop_req = 1'b0;
      if (restart) begin
         cnt_n = count_up ? '0 : load_v;
         pwm_n = 1'b1;
      end else if (en) begin
         case (op)
            OP_ONESHOT, OP_PERIODIC: begin
               if (ie && (cnt == match_v)) flag_set[FLG_MT] = 1'b1;
               if (at_end) begin
                  flag_set[FLG_TO] = 1'b1;
                  if (op == OP_PERIODIC) cnt_n = count_up ? '0 : load_v;
                  else                   stop_req = 1'b1;
               end else begin
                  cnt_n = count_up ? inc : dec;
               end
            end
            OP_PWM: begin
               if (cnt == '0) begin
                  cnt_n = load_v;
                  pwm_n = 1'b1;
               end else begin
                  cnt_n = dec;
                  if (cnt == match_v) pwm_n = 1'b0;
               end
            end
            OP_EDGE_CNT: begin
               if (rise) begin
                  capt_n = dec;
                  if (dec == match_v) begin
                     flag_set[FLG_CAP] = 1'b1;
                     cnt_n = load_v;
                  end else begin
                     cnt_n = dec;
                  end
               end
            end
            OP_EDGE_TIME: begin
               cnt_n = (cnt == '0) ? load_v : dec;
               if (rise) begin
                  capt_n = cnt;
                  flag_set[FLG_CAP] = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         capt  <= '0;
         pwm_q <= 1'b0;
      end else begin
         cnt   <= cnt_n;
         capt  <= capt_n;
         pwm_q <= pwm_n;
      end
   end

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              cap_in,
   output logic              pwm_o,
   output logic [CNT_W-1:0]  capt_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              run_o,
   output logic              irq_to_o,
   output logic              irq_mt_o,
   output logic              irq_cap_o
);

   initial begin
      assert (CNT_W >= CTRL_BITS + 1) else $error("CNT_W too small for control word");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t            ctrl;
   op_e              op;
   logic [CNT_W-1:0] load_v, match_v;
   logic             restart, rise, stop_req, pwm_q;
   logic [N_FLG-1:0] flags, flag_set;

   assign op = decode_op(ctrl);

   gpt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .stop_req (stop_req),
      .flag_set (flag_set),
      .ctrl     (ctrl),
      .load_v   (load_v),
      .match_v  (match_v),
      .restart  (restart),
      .flags    (flags)
   );

   gpt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_in),
      .rise  (rise)
   );

   gpt_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .en       (ctrl.en),
      .up       (ctrl.up),
      .ie       (ctrl.ie),
      .load_v   (load_v),
      .match_v  (match_v),
      .restart  (restart),
      .rise     (rise),
      .cnt      (cnt_o),
      .capt     (capt_o),
      .pwm_q    (pwm_q),
      .flag_set (flag_set),
      .stop_req (stop_req)
   );

   assign pwm_o     = pwm_q && ctrl.en && (op == OP_PWM);
   assign run_o     = ctrl.en;
   assign irq_to_o  = flags[FLG_TO];
   assign irq_mt_o  = flags[FLG_MT];
   assign irq_cap_o = flags[FLG_CAP];

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
   parameter int CNT_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic              cap_in,
   input logic              pwm_o,
   input logic [CNT_W-1:0]  capt_o,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              run_o,
   input logic              irq_to_o,
   input logic              irq_mt_o,
   input logic              irq_cap_o
);

   logic [6:0] sh;
   logic       ctrl_wr, clr_wr, sh_pwm, sh_cap, up_wr;
   logic       unused_chk;

   assign ctrl_wr = wr_en && (wr_addr == 2'd0);
   assign clr_wr  = wr_en && (wr_addr == 2'd3);
   assign sh_pwm  = sh[3] && !sh[2] && (sh[1:0] == 2'd1 || sh[1:0] == 2'd2);
   assign sh_cap  = !sh[3] && (sh[1:0] == 2'd3);
   assign up_wr   = ctrl_wr && wr_data[4] && !wr_data[3]
                    && (wr_data[1:0] == 2'd1 || wr_data[1:0] == 2'd2);
   assign unused_chk = ^{cap_in, capt_o, wr_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh <= '0;
      else if (ctrl_wr) sh <= wr_data[6:0];
   end

   // R12: flags fall only after a clear write naming them
   p_to_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_to_o) |-> $past(clr_wr && wr_data[0]));
   p_mt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_mt_o) |-> $past(clr_wr && wr_data[1]));
   p_cap_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_cap_o) |-> $past(clr_wr && wr_data[2]));

   // R4: enable drops only at a timeout or by a control write
   p_run_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_o) |-> (irq_to_o || $past(ctrl_wr)));

   // R7: modulated output only in the legal PWM combination
   p_pwm_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_o |-> sh_pwm);

   // R7: PWM counter steps down by one unless it reloads
   p_pwm_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sh_pwm && run_o) && !$past(ctrl_wr, 2) && ($past(cnt_o) != '0))
      |-> ((cnt_o + 1'b1) == $past(cnt_o)));

   // R6: up-counting timer starts from zero
   p_up_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_wr, 2) && !$past(ctrl_wr)) |-> (cnt_o == '0));

   // R8: compare flag needs its enable
   p_mt_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_mt_o) |-> $past(sh[5]));

   // R9: capture flag only from a capture mode
   p_cap_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_cap_o) |-> $past(sh_cap));

endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .cap_in    (cap_in),
   .pwm_o     (pwm_o),
   .capt_o    (capt_o),
   .cnt_o     (cnt_o),
   .run_o     (run_o),
   .irq_to_o  (irq_to_o),
   .irq_mt_o  (irq_mt_o),
   .irq_cap_o (irq_cap_o)
);

// File: tb/sim_gpt_timer.sv
`timescale 1ns/1ps
module sim_gpt_timer;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          cap_in = 1'b0;
   logic          pwm_o, run_o, irq_to_o, irq_mt_o, irq_cap_o;
   logic [W-1:0]  capt_o, cnt_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpt_timer #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cap_in(cap_in), .pwm_o(pwm_o), .capt_o(capt_o),
      .cnt_o(cnt_o), .run_o(run_o), .irq_to_o(irq_to_o),
      .irq_mt_o(irq_mt_o), .irq_cap_o(irq_cap_o)
   );

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [15:0] load;
      logic [15:0] match;
      logic [7:0]  n;
      logic [15:0] ecnt;
      logic [2:0]  eflg;
      logic        erun;
      logic        epwm;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{8'h41, 16'd3, 16'd9, 8'd4, 16'd0, 3'b000, 1'b1, 1'b0, 8'd4},  // R4 before end
      '{8'h41, 16'd3, 16'd9, 8'd5, 16'd0, 3'b001, 1'b0, 1'b0, 8'd4},  // R4 timeout
      '{8'h41, 16'd3, 16'd9, 8'd8, 16'd0, 3'b001, 1'b0, 1'b0, 8'd4},  // R4 halted
      '{8'h42, 16'd3, 16'd9, 8'd5, 16'd3, 3'b001, 1'b1, 1'b0, 8'd5},  // R5 reload
      '{8'h42, 16'd3, 16'd9, 8'd7, 16'd1, 3'b001, 1'b1, 1'b0, 8'd5},  // R5 runs on
      '{8'h51, 16'd3, 16'd9, 8'd4, 16'd3, 3'b000, 1'b1, 1'b0, 8'd6},  // R6 up
      '{8'h51, 16'd3, 16'd9, 8'd5, 16'd3, 3'b001, 1'b0, 1'b0, 8'd6},  // R6 up end
      '{8'h52, 16'd3, 16'd9, 8'd6, 16'd1, 3'b001, 1'b1, 1'b0, 8'd6},  // R6 up wrap
      '{8'h61, 16'd5, 16'd2, 8'd4, 16'd2, 3'b000, 1'b1, 1'b0, 8'd8},  // R8 not yet
      '{8'h61, 16'd5, 16'd2, 8'd5, 16'd1, 3'b010, 1'b1, 1'b0, 8'd8},  // R8 hit
      '{8'h41, 16'd5, 16'd2, 8'd6, 16'd0, 3'b000, 1'b1, 1'b0, 8'd8},  // R8 disabled
      '{8'h72, 16'd5, 16'd2, 8'd4, 16'd3, 3'b010, 1'b1, 1'b0, 8'd8},  // R8 up
      '{8'h40, 16'd5, 16'd2, 8'd4, 16'd5, 3'b000, 1'b1, 1'b0, 8'd2},  // R2 reserved
      '{8'h69, 16'd5, 16'd2, 8'd6, 16'd0, 3'b000, 1'b1, 1'b0, 8'd7},  // R7 no compare flag
      '{8'h79, 16'd5, 16'd2, 8'd3, 16'd3, 3'b000, 1'b1, 1'b1, 8'd7},  // R7 up ignored
      '{8'h4D, 16'd5, 16'd2, 8'd4, 16'd5, 3'b000, 1'b1, 1'b0, 8'd2},  // R2 illegal combo
      '{8'h01, 16'd5, 16'd2, 8'd4, 16'd5, 3'b000, 1'b0, 1'b0, 8'd3}   // R3 disabled init
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input logic [W-1:0] ld, input logic [W-1:0] mt);
      wr(2'd0, '0);
      wr(2'd3, 16'h7);
      wr(2'd1, ld);
      wr(2'd2, mt);
   endtask

   task automatic pulse();
      cap_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cap_in = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      int highs;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "cnt", cnt_o, 0);
      chk("R1", "capt", capt_o, 0);
      chk("R1", "flags", {irq_cap_o, irq_mt_o, irq_to_o}, 0);
      chk("R1", "run", run_o, 0);
      chk("R1", "pwm", pwm_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cnt after release", cnt_o, 0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", TBL[i].req);
         setup(TBL[i].load, TBL[i].match);
         wr(2'd0, {8'h00, TBL[i].ctrl});
         repeat (int'(TBL[i].n)) @(posedge clk);
         @(negedge clk);
         chk(tag, $sformatf("vec%0d cnt", i), cnt_o, TBL[i].ecnt);
         chk(tag, $sformatf("vec%0d flags", i), {irq_cap_o, irq_mt_o, irq_to_o}, TBL[i].eflg);
         chk(tag, $sformatf("vec%0d run", i), run_o, TBL[i].erun);
         chk(tag, $sformatf("vec%0d pwm", i), pwm_o, TBL[i].epwm);
      end

      // R7 waveform: reload 4, compare 1, period 5 with one low cycle
      setup(16'd4, 16'd1);
      wr(2'd0, 16'h004A);
      highs = 0;
      for (int k = 1; k <= 10; k++) begin
         @(posedge clk);
         @(negedge clk);
         highs += int'(pwm_o);
         if (k == 4) chk("R7", "pwm high before compare", pwm_o, 1);
         if (k == 5) chk("R7", "pwm low after compare", pwm_o, 0);
         if (k == 6) chk("R7", "pwm high after reload", pwm_o, 1);
      end
      chk("R7", "high cycles in two periods", highs, 8);

      // R9 and R11: edge count with synchronizer latency
      setup(16'd5, 16'd3);
      wr(2'd0, 16'h0043);
      cap_in = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R11", "no action before third edge", cnt_o, 5);
      @(posedge clk); @(negedge clk);
      chk("R11", "acted on third edge", cnt_o, 4);
      repeat (3) @(posedge clk);
      @(negedge clk);
      cap_in = 1'b0;
      chk("R11", "held pin counts once", cnt_o, 4);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R9", "capt after first", capt_o, 4);
      chk("R9", "no flag yet", irq_cap_o, 0);
      pulse();
      chk("R9", "reload on threshold", cnt_o, 5);
      chk("R9", "capt threshold", capt_o, 3);
      chk("R9", "capture flag", irq_cap_o, 1);

      // R10 edge time
      setup(16'd1000, 16'd0);
      wr(2'd0, 16'h0047);
      repeat (10) @(posedge clk);
      @(negedge clk);
      cap_in = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      v = cnt_o;
      @(posedge clk); @(negedge clk);
      chk("R10", "timestamp", capt_o, v);
      chk("R10", "counter keeps running", cnt_o, v - 1'b1);
      chk("R10", "capture flag", irq_cap_o, 1);
      cap_in = 1'b0;

      // R12 per-bit clear
      setup(16'd2, 16'd1);
      wr(2'd0, 16'h0061);
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R12", "both flags set", {irq_cap_o, irq_mt_o, irq_to_o}, 3'b011);
      wr(2'd3, 16'h0001);
      chk("R12", "timeout cleared only", {irq_cap_o, irq_mt_o, irq_to_o}, 3'b010);
      wr(2'd3, 16'h0002);
      chk("R12", "compare cleared", {irq_cap_o, irq_mt_o, irq_to_o}, 3'b000);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule